// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block is the data-register side of a test-access path that lets an external host reach a small addressed register space inside a chip. It runs on the test clock. The capture, shift and update phase flags and the current instruction come from a separate TAP controller, which is not part of this block. A 5-bit chain-select register, loaded under its own instruction, decides which scan chain is live. When chain 0 is selected and the access instruction is loaded, a 40-bit access frame can be shifted through. The block then turns each completed frame into a single read or write strobe on a simple register bus toward a peripheral.

Reads are pipelined. The update of a read scan fetches the addressed register and holds the value. The next scan captures that value and shifts it out in its data field. A host therefore finishes a burst of reads by reading address 0, which has no side effect, so it never triggers a second access to a register that changes when it is read. A write takes effect at the update of its own scan and leaves the held read value unchanged.

Top module: `scan_reg_access`

## Requirements
- R1: After reset the chain-select register holds all ones (5'h1F), so no chain is selected. The held read value is 0.
- R2: When the instruction is 4'h2, the 5-bit chain-select shift register does three things. At capture it loads the current selection. It shifts least significant bit first from tdi. At update its content becomes the new selection.
- R3: When the instruction is 4'hC and chain 0 is selected, a 40-bit frame shifts least significant bit first. Bits [31:0] are the data field, bits [38:32] the register address and bit 39 the direction (1 = write, 0 = read). No scan ever asserts bus_rd and bus_wr together.
- R4: The update of a write frame asserts bus_wr for exactly that one update cycle, with bus_addr and bus_wdata taken from the frame.
- R5: The update of a read frame asserts bus_rd for exactly that one update cycle, with bus_addr taken from the frame. The block stores bus_rdata as the held read value, so a register with read side effects is accessed once per read scan.
- R6: At capture of an access frame, the data field loads the held read value and bits [39:32] load 0. The result of a read therefore appears in the next scan.
- R7: A write scan leaves the held read value unchanged.
- R8: An access scan is ignored unless the instruction is 4'hC and chain 0 is selected. It produces no strobe, leaves the held value alone, and tdo stays 0 when neither instruction 4'h2 nor 4'hC with chain 0 is active.
- R9: tdo shows bit 0 of the active shift register before each shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 4 | Current instruction from the TAP controller |
| capture_dr | input | 1 | TAP is in the data-register capture state |
| shift_dr | input | 1 | TAP is in the data-register shift state |
| update_dr | input | 1 | TAP is in the data-register update state |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| bus_rd | output | 1 | Read strobe toward the peripheral |
| bus_wr | output | 1 | Write strobe toward the peripheral |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data from the peripheral, combinational on bus_addr |

## Verification
The hardest case to reach is proving that a read of a side-effecting register happens exactly once. Two things in the pipeline could go wrong: the read result could arrive one scan late, or a naive final read could trigger the side effect a second time. The bench models a peripheral with a counter at address 4 that advances on every read. It reads that address twice and then address 0. The scans must return 0 and then 1, and the counter must end at 2. A second hard case is a scan that is silently dropped. To cover it, the bench first moves the chain select away from 0, and separately loads an unrelated instruction. It then shows through a later read-back that the dropped write left the register untouched.

// File: rtl/scan_reg_access_pkg.sv
package scan_reg_access_pkg;
    localparam int DEF_DATA_W  = 32;
    localparam int DEF_ADDR_W  = 7;
    localparam int DEF_CHAIN_W = 5;
    localparam int DEF_IR_W    = 4;

    // TAP phase flags as seen by one data register
    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } tap_ctl_t;
endpackage

// File: rtl/chain_select_reg.sv
module chain_select_reg
    import scan_reg_access_pkg::*;
#(
    parameter int CHAIN_W = DEF_CHAIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  tap_ctl_t           ctl,
    input  logic               tdi,
    output logic [CHAIN_W-1:0] sel_q,
    output logic               tdo_bit
);
    typedef struct packed {
        logic [CHAIN_W-1:0] sr;
        logic [CHAIN_W-1:0] sel;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (ctl.capture) begin
                st_d.sr = st_q.sel;
            end else if (ctl.shift) begin
                st_d.sr = {tdi, st_q.sr[CHAIN_W-1:1]};
            end else if (ctl.update) begin
                st_d.sel = st_q.sr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sr: '1, sel: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q   = st_q.sel;
    assign tdo_bit = st_q.sr[0];
endmodule

// File: rtl/access_shifter.sv
module access_shifter
    import scan_reg_access_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  tap_ctl_t          ctl,
    input  logic              tdi,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              tdo_bit,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] frame_data
);
    localparam int FRAME_W = DATA_W + ADDR_W + 1;
    localparam int RW_BIT  = FRAME_W - 1;

    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [DATA_W-1:0]  hold;
    } st_t;

    st_t  st_d, st_q;
    logic is_write;
    logic do_update;

    assign is_write  = st_q.sr[RW_BIT];
    assign do_update = en & ctl.update;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (ctl.capture) begin
                st_d.sr = {{(ADDR_W + 1){1'b0}}, st_q.hold};
            end else if (ctl.shift) begin
                st_d.sr = {tdi, st_q.sr[FRAME_W-1:1]};
            end else if (ctl.update && !is_write) begin
                st_d.hold = bus_rdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rd     = do_update & ~is_write;
    assign bus_wr     = do_update & is_write;
    assign bus_addr   = st_q.sr[RW_BIT-1 -: ADDR_W];
    assign bus_wdata  = st_q.sr[DATA_W-1:0];
    assign tdo_bit    = st_q.sr[0];
    assign hold_q     = st_q.hold;
    assign frame_data = st_q.sr[DATA_W-1:0];
endmodule

// File: rtl/scan_reg_access.sv
module scan_reg_access
    import scan_reg_access_pkg::*;
#(
    parameter int                     DATA_W    = DEF_DATA_W,
    parameter int                     ADDR_W    = DEF_ADDR_W,
    parameter int                     CHAIN_W   = DEF_CHAIN_W,
    parameter int                     IR_W      = DEF_IR_W,
    parameter logic [DEF_IR_W-1:0]    IR_SEL    = 4'h2,
    parameter logic [DEF_IR_W-1:0]    IR_ACC    = 4'hC,
    parameter logic [DEF_CHAIN_W-1:0] ACC_CHAIN = '0
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic [3:0]        ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [6:0]        bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata
);
    tap_ctl_t           ctl;
    logic               sel_act;
    logic               acc_act;
    logic               sel_tdo;
    logic               acc_tdo;
    logic [CHAIN_W-1:0] chain_q;
    logic [DATA_W-1:0]  acc_hold;
    logic [DATA_W-1:0]  acc_data;

    assign ctl     = '{capture: capture_dr, shift: shift_dr, update: update_dr};
    assign sel_act = (ir == IR_SEL[IR_W-1:0]);
    assign acc_act = (ir == IR_ACC[IR_W-1:0]) && (chain_q == ACC_CHAIN[CHAIN_W-1:0]);

    chain_select_reg #(.CHAIN_W(CHAIN_W)) u_sel (
        .clk     (tck),
        .rst_n   (rst_n),
        .en      (sel_act),
        .ctl     (ctl),
        .tdi     (tdi),
        .sel_q   (chain_q),
        .tdo_bit (sel_tdo)
    );

    access_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
        .clk        (tck),
        .rst_n      (rst_n),
        .en         (acc_act),
        .ctl        (ctl),
        .tdi        (tdi),
        .bus_rdata  (bus_rdata),
        .tdo_bit    (acc_tdo),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .hold_q     (acc_hold),
        .frame_data (acc_data)
    );

    always_comb begin
        if (sel_act) begin
            tdo = sel_tdo;
        end else if (acc_act) begin
            tdo = acc_tdo;
        end else begin
            tdo = 1'b0;
        end
    end
endmodule

// File: rtl/scan_reg_access_chk.sv
module scan_reg_access_chk #(
    parameter int              IR_W      = 4,
    parameter int              CHAIN_W   = 5,
    parameter int              DATA_W    = 32,
    parameter logic [IR_W-1:0] IR_ACC    = 4'hC,
    parameter logic [CHAIN_W-1:0] ACC_CHAIN = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IR_W-1:0]    ir,
    input logic               capture_dr,
    input logic               update_dr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [CHAIN_W-1:0] chain_q,
    input logic [DATA_W-1:0]  hold_q,
    input logic [DATA_W-1:0]  frame_data
);
    logic live;
    assign live = (ir == IR_ACC) && (chain_q == ACC_CHAIN);

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_wr_at_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> update_dr);

    assert_rd_at_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> update_dr);

    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_dr && live) |=> (frame_data == $past(hold_q)));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(hold_q));

    assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> live);
endmodule

bind scan_reg_access scan_reg_access_chk #(
    .IR_W(IR_W), .CHAIN_W(CHAIN_W), .DATA_W(DATA_W),
    .IR_ACC(IR_ACC[IR_W-1:0]), .ACC_CHAIN(ACC_CHAIN[CHAIN_W-1:0])
) u_chk (
    .clk        (tck),
    .rst_n      (rst_n),
    .ir         (ir),
    .capture_dr (capture_dr),
    .update_dr  (update_dr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .chain_q    (chain_q),
    .hold_q     (acc_hold),
    .frame_data (acc_data)
);

// File: tb/test_scan_reg_access.sv
module test_scan_reg_access;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ir = 4'h0;
    logic        cap = 1'b0, sh = 1'b0, up = 1'b0, tdi = 1'b0;
    logic        tdo, bus_rd, bus_wr;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;

    localparam logic [31:0] ID_VAL = 32'h1D0C_0001;

    always #2.5 clk = ~clk;

    scan_reg_access i_scan_reg_access (
        .tck(clk), .rst_n(rst_n), .ir(ir), .capture_dr(cap), .shift_dr(sh),
        .update_dr(up), .tdi(tdi), .tdo(tdo), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Peripheral model: addr 0 constant, addr 4 read-advancing counter
    logic [31:0] mem [8];
    int          side_cnt = 0;
    int          n_rd = 0, n_wr = 0;

    always_comb begin
        if (bus_addr == 7'd0)      bus_rdata = ID_VAL;
        else if (bus_addr == 7'd4) bus_rdata = side_cnt;
        else                       bus_rdata = mem[bus_addr[2:0]];
    end

    always @(posedge clk) begin
        if (bus_rd) begin
            n_rd <= n_rd + 1;
            if (bus_addr == 7'd4) side_cnt <= side_cnt + 1;
        end
        if (bus_wr) begin
            n_wr <= n_wr + 1;
            if (bus_addr != 7'd0 && bus_addr != 7'd4) mem[bus_addr[2:0]] <= bus_wdata;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic scan(input int n, input logic [39:0] din, output logic [39:0] dout);
        dout = '0;
        @(negedge clk); cap = 1'b1; @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cap = 1'b0; sh = 1'b1; tdi = din[i]; dout[i] = tdo;
            @(posedge clk);
        end
        @(negedge clk); sh = 1'b0; up = 1'b1; @(posedge clk);
        @(negedge clk); up = 1'b0;
    endtask

    // {rw, addr, wdata, expected data field shifted out}
    localparam logic [71:0] VEC [12] = '{
        {1'b1, 7'd1, 32'h1234_5678, 32'h0000_0000},
        {1'b0, 7'd1, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 7'd2, 32'h0000_0000, 32'h1234_5678},
        {1'b1, 7'd2, 32'hCAFE_F00D, 32'hA000_0002},
        {1'b0, 7'd2, 32'h0000_0000, 32'hA000_0002},
        {1'b0, 7'd0, 32'h0000_0000, 32'hCAFE_F00D},
        {1'b0, 7'd4, 32'h0000_0000, ID_VAL},
        {1'b0, 7'd4, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 7'd0, 32'h0000_0000, 32'h0000_0001},
        {1'b1, 7'd7, 32'hFFFF_FFFF, ID_VAL},
        {1'b0, 7'd7, 32'h0000_0000, ID_VAL},
        {1'b0, 7'd0, 32'h0000_0000, 32'hFFFF_FFFF}
    };

    initial begin
        logic [39:0] dout;
        int          rd0, wr0;
        for (int i = 0; i < 8; i++) mem[i] = 32'hA000_0000 + i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R8: reset state, chain 31 selected, access scan ignored
        check("R8 tdo idle after reset", {63'd0, tdo}, 64'd0);
        ir = 4'hC; rd0 = n_rd; wr0 = n_wr;
        scan(40, {1'b1, 7'd1, 32'h0000_5555}, dout);
        check("R8 no strobe with reset chain", {32'(n_rd - rd0), 32'(n_wr - wr0)}, 64'd0);
        check("R8 tdo zero with reset chain", {24'd0, dout}, 64'd0);

        // R1 / R2: chain-select capture shows reset value, then select chain 0
        ir = 4'h2;
        scan(5, 40'd0, dout);
        check("R1 chain select reset value", {59'd0, dout[4:0]}, 64'h1F);
        ir = 4'hC;

        // R3-R7, R9: vector walk
        for (int v = 0; v < 12; v++) begin
            rd0 = n_rd; wr0 = n_wr;
            scan(40, VEC[v][71:32], dout);
            check($sformatf("R6 R9 vec %0d data field", v), {32'd0, dout[31:0]}, {32'd0, VEC[v][31:0]});
            check($sformatf("R6 vec %0d upper bits zero", v), {56'd0, dout[39:32]}, 64'd0);
            if (VEC[v][71])
                check($sformatf("R4 vec %0d one write strobe", v), {32'(n_rd - rd0), 32'(n_wr - wr0)}, {32'd0, 32'd1});
            else
                check($sformatf("R5 vec %0d one read strobe", v), {32'(n_rd - rd0), 32'(n_wr - wr0)}, {32'd1, 32'd0});
        end
        check("R5 side-effect register read once per scan", 64'(side_cnt), 64'd2);
        check("R4 write landed at addr 2", {32'd0, mem[2]}, {32'd0, 32'hCAFE_F00D});

        // R8: non-zero chain drops the scan
        ir = 4'h2;
        scan(5, 40'd3, dout);
        ir = 4'hC; rd0 = n_rd; wr0 = n_wr;
        scan(40, {1'b1, 7'd1, 32'h0000_DEAD}, dout);
        check("R8 chain 3 no strobe", {32'(n_rd - rd0), 32'(n_wr - wr0)}, 64'd0);
        check("R8 chain 3 tdo zero", {24'd0, dout}, 64'd0);

        // R2: selection read back, then back to chain 0
        ir = 4'h2;
        scan(5, 40'd0, dout);
        check("R2 chain select captures 3", {59'd0, dout[4:0]}, 64'd3);

        // R8: unrelated instruction with chain 0
        ir = 4'hF; rd0 = n_rd; wr0 = n_wr;
        scan(40, {1'b1, 7'd1, 32'h0000_BEEF}, dout);
        check("R8 other instruction no strobe", {32'(n_rd - rd0), 32'(n_wr - wr0)}, 64'd0);
        check("R8 other instruction tdo zero", {24'd0, dout}, 64'd0);

        // R7 / R8: held value and addr 1 untouched by dropped scans
        ir = 4'hC;
        scan(40, {1'b0, 7'd1, 32'd0}, dout);
        check("R8 held value survives dropped scans", {32'd0, dout[31:0]}, {32'd0, ID_VAL});
        scan(40, {1'b0, 7'd0, 32'd0}, dout);
        check("R8 addr 1 not written by dropped scans", {32'd0, dout[31:0]}, {32'd0, 32'h1234_5678});

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule